// File: doc/BRIEF.md
# Shared Endpoint Buffer Allocator

This block divides one shared packet-buffer memory among the sixteen logical endpoint buffers of a USB peripheral controller. Two control buffers (index 0 for host-to-device and index 1 for device-to-host) always take 64 bytes each. The fourteen configurable endpoints (indices 2 to 15) each take space according to their enable bit, a 4-bit size code, an isochronous flag and a double-buffer flag. A disabled endpoint takes nothing.

A one-cycle request starts a recompute. The block samples the configuration at that edge. It then walks the buffers one per clock in ascending index order and packs each allocated buffer directly after the previous allocated one. The walk checks every buffer against a fixed byte budget. A buffer that does not fit gets no space, but later buffers that do fit are still placed. When the walk ends, the new layout is published together with a done pulse. If any start address or length moved, a flush pulse marks the contents of every FIFO as undefined. An over-capacity flag records any walk that ran out of room and stays set until reset.

Top module: `ep_fifo_alloc`

## Requirements
- R1: After reset, index 0 has base 0 and length 64, index 1 has base 64 and length 64, and all other indices have base 0 and length 0. `buf_ok` is 16'h0003, and `over_err`, `alloc_done`, `fifo_flush` and `alloc_busy` are all low.
- R2: Buffer index k occupies `buf_base[12k+11:12k]`, `buf_len[11k+10:11k]` and `buf_ok[k]`. Indices 0 and 1 are the control buffers and always get 64 bytes. Configurable endpoint n (1..14) is index n+1 and is configured by bit n-1 of `ep_en`, `ep_iso` and `ep_dbl`, and by bits [4n-1:4n-4] of `ep_code`.
- R3: An endpoint with its `ep_en` bit low gets base 0, length 0 and a clear `buf_ok` bit, whatever its other settings.
- R4: With the isochronous bit low, size codes 0, 1 and 2 give 8, 16 and 32 bytes. Code 3 and every higher code give 64 bytes.
- R5: With the isochronous bit high, codes 0 to 15 give 16, 32, 48, 64, 96, 128, 160, 192, 256, 320, 384, 512, 640, 768, 896 and 1023 bytes.
- R6: A configurable endpoint with its `ep_dbl` bit high takes twice its coded size. The reported length is the full two-buffer footprint.
- R7: Allocated buffers are packed in ascending index order from address 0. Each allocated buffer starts at the sum of the lengths of all allocated buffers with a lower index.
- R8: A buffer is allocated only if its end does not pass 2462 bytes. Ending exactly at 2462 is allowed. A buffer that does not fit gets base 0, length 0 and a clear `buf_ok` bit, and later buffers that fit are still allocated.
- R9: `over_err` goes high with the done pulse of any walk in which an enabled buffer did not fit, and stays high until reset.
- R10: A request accepted at a clock edge produces a one-cycle `alloc_done` pulse visible after the 17th following edge. `alloc_busy` is high from that edge until done. The published layout does not change before done.
- R11: A request made while `alloc_busy` is high is ignored, and configuration changes after the accepted request do not affect that walk.
- R12: `fifo_flush` pulses together with `alloc_done` exactly when some buffer's base or length differs from the previously published layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Recompute request strobe |
| ep_en | input | 14 | Enable per configurable endpoint |
| ep_code | input | 56 | 4-bit size code per configurable endpoint |
| ep_iso | input | 14 | Isochronous size-table select per endpoint |
| ep_dbl | input | 14 | Double-buffer select per endpoint |
| alloc_busy | output | 1 | Walk in progress |
| alloc_done | output | 1 | One-cycle pulse when the new layout is published |
| fifo_flush | output | 1 | One-cycle pulse: all FIFO contents are invalid |
| over_err | output | 1 | Sticky over-capacity flag |
| buf_ok | output | 16 | Buffer allocated, per index |
| buf_base | output | 192 | Start address per index, 12 bits each |
| buf_len | output | 176 | Allocated bytes per index, 11 bits each |

## Verification
The bench builds a layout that ends exactly on the 2462-byte budget. A capacity compare that is off by one would reject the last buffer and raise the error. Another layout has a mid-walk buffer that overflows while later, smaller buffers still fit. A design that stopped at the first miss, or that advanced the cursor past the rejected buffer, would misplace or drop them. The bench repeats an identical configuration to catch a flush that fires on every walk. It also re-requests and changes the configuration mid-walk to expose a design that restarts or samples late. Finally, it reads a disabled endpoint whose size, isochronous and double-buffer settings are all non-zero, to catch a design that lets those settings leak into the layout.

// File: rtl/ep_alloc_pkg.sv
// Shared types and the size-code decode for the endpoint buffer allocator.
// Assumes every single-buffer size fits in LEN_W-1 bits, so a doubled
// footprint fits in LEN_W bits.
package ep_alloc_pkg;

    localparam int LEN_W  = 11;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_COMMIT = 2'd2
    } walk_state_t;

    // Bytes for one buffer of the given size code and table select.
    function automatic logic [LEN_W-1:0] ep_bytes(input logic [CODE_W-1:0] code,
                                                  input logic iso);
        logic [LEN_W-1:0] b;
        if (!iso) begin
            b = (code >= 4'd3) ? LEN_W'(64) : (LEN_W'(8) << code);
        end else begin
            case (code)
                4'd0:    b = LEN_W'(16);
                4'd1:    b = LEN_W'(32);
                4'd2:    b = LEN_W'(48);
                4'd3:    b = LEN_W'(64);
                4'd4:    b = LEN_W'(96);
                4'd5:    b = LEN_W'(128);
                4'd6:    b = LEN_W'(160);
                4'd7:    b = LEN_W'(192);
                4'd8:    b = LEN_W'(256);
                4'd9:    b = LEN_W'(320);
                4'd10:   b = LEN_W'(384);
                4'd11:   b = LEN_W'(512);
                4'd12:   b = LEN_W'(640);
                4'd13:   b = LEN_W'(768);
                4'd14:   b = LEN_W'(896);
                default: b = LEN_W'(1023);
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/ep_alloc_seq.sv
// Walk sequencer: accepts a request when idle, then steps a buffer index
// once per clock over all NUM_BUF buffers, then spends one commit cycle.
// Assumes the request is a level sampled at the clock edge; requests
// seen while not idle are dropped.
module ep_alloc_seq
    import ep_alloc_pkg::*;
#(
    parameter int NUM_BUF = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    output logic             start,
    output logic             step_en,
    output logic [IDX_W-1:0] step_idx,
    output logic             commit,
    output logic             busy
);

    walk_state_t      state_q;
    logic [IDX_W-1:0] idx_q;

    // Decode phase strobes from the state.
    always_comb begin
        start    = req && (state_q == ST_IDLE);
        step_en  = (state_q == ST_WALK);
        commit   = (state_q == ST_COMMIT);
        busy     = (state_q != ST_IDLE);
        step_idx = idx_q;
    end

    // Advance the state and the buffer index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        state_q <= ST_WALK;
                        idx_q   <= '0;
                    end
                end
                ST_WALK: begin
                    if (idx_q == IDX_W'(NUM_BUF - 1)) begin
                        state_q <= ST_COMMIT;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ep_size_decode.sv
// Footprint decode for the buffer under the walk index.
// Indices 0 and 1 are the fixed control buffers. Index k+2 is configurable
// endpoint k. Output is the byte need and whether the buffer wants space.
module ep_size_decode
    import ep_alloc_pkg::*;
#(
    parameter int NUM_CFG    = 14,
    parameter int IDX_W      = 4,
    parameter int CTRL_BYTES = 64
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_CFG-1:0]        en,
    input  logic [NUM_CFG*CODE_W-1:0] code,
    input  logic [NUM_CFG-1:0]        iso,
    input  logic [NUM_CFG-1:0]        dbl,
    output logic                      want,
    output logic [LEN_W-1:0]          need
);

    // Select and size the indexed buffer.
    always_comb begin
        want = 1'b0;
        need = '0;
        if (idx < IDX_W'(2)) begin
            want = 1'b1;
            need = LEN_W'(CTRL_BYTES);
        end
        for (int k = 0; k < NUM_CFG; k++) begin
            if (idx == IDX_W'(k + 2)) begin
                want = en[k];
                need = ep_bytes(code[k*CODE_W +: CODE_W], iso[k]);
                if (dbl[k]) begin
                    need = need << 1;
                end
            end
        end
    end

endmodule

// File: rtl/ep_layout_commit.sv
// Published layout store. On the commit strobe it copies the working
// layout out, pulses done, pulses flush when any base or length moved,
// and folds the walk's overflow into the sticky error.
// Reset layout holds only the two control buffers.
module ep_layout_commit
    import ep_alloc_pkg::*;
#(
    parameter int NUM_BUF    = 16,
    parameter int ADDR_W     = 12,
    parameter int CTRL_BYTES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [NUM_BUF*ADDR_W-1:0] work_base,
    input  logic [NUM_BUF*LEN_W-1:0]  work_len,
    input  logic [NUM_BUF-1:0]        work_ok,
    input  logic                      work_over,
    output logic [NUM_BUF*ADDR_W-1:0] pub_base,
    output logic [NUM_BUF*LEN_W-1:0]  pub_len,
    output logic [NUM_BUF-1:0]        pub_ok,
    output logic                      done,
    output logic                      flush,
    output logic                      err
);

    localparam int BASE_BITS = NUM_BUF * ADDR_W;
    localparam int LEN_BITS  = NUM_BUF * LEN_W;
    localparam logic [BASE_BITS-1:0] RST_BASE = BASE_BITS'(CTRL_BYTES) << ADDR_W;
    localparam logic [LEN_BITS-1:0]  RST_LEN  =
        (LEN_BITS'(CTRL_BYTES) << LEN_W) | LEN_BITS'(CTRL_BYTES);
    localparam logic [NUM_BUF-1:0]   RST_OK   = NUM_BUF'(3);

    logic moved;

    // Any base or length differs from what is published.
    always_comb moved = (work_base != pub_base) || (work_len != pub_len);

    // Publish the layout and raise the completion strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_base <= RST_BASE;
            pub_len  <= RST_LEN;
            pub_ok   <= RST_OK;
            done     <= 1'b0;
            flush    <= 1'b0;
            err      <= 1'b0;
        end else begin
            done  <= commit;
            flush <= commit && moved;
            if (commit) begin
                pub_base <= work_base;
                pub_len  <= work_len;
                pub_ok   <= work_ok;
                err      <= err | work_over;
            end
        end
    end

endmodule

// File: rtl/ep_fifo_alloc.sv
// Shared endpoint buffer allocator (top).
// Samples the endpoint configuration on an accepted request, packs every
// buffer that fits under BUDGET in ascending index order one per clock,
// then publishes the layout. Buffers that do not fit get nothing and do
// not advance the fill cursor.
module ep_fifo_alloc
    import ep_alloc_pkg::*;
#(
    parameter int NUM_CFG    = 14,
    parameter int BUDGET     = 2462,
    parameter int CTRL_BYTES = 64,
    localparam int NUM_BUF   = NUM_CFG + 2,
    localparam int ADDR_W    = $clog2(BUDGET + 1),
    localparam int IDX_W     = $clog2(NUM_BUF)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_req,
    input  logic [NUM_CFG-1:0]        ep_en,
    input  logic [NUM_CFG*CODE_W-1:0] ep_code,
    input  logic [NUM_CFG-1:0]        ep_iso,
    input  logic [NUM_CFG-1:0]        ep_dbl,
    output logic                      alloc_busy,
    output logic                      alloc_done,
    output logic                      fifo_flush,
    output logic                      over_err,
    output logic [NUM_BUF-1:0]        buf_ok,
    output logic [NUM_BUF*ADDR_W-1:0] buf_base,
    output logic [NUM_BUF*LEN_W-1:0]  buf_len
);

    localparam int SUM_W = ADDR_W + 1;

    logic                      start, step_en, commit;
    logic [IDX_W-1:0]          step_idx;
    logic [NUM_CFG-1:0]        en_q, iso_q, dbl_q;
    logic [NUM_CFG*CODE_W-1:0] code_q;
    logic                      want;
    logic [LEN_W-1:0]          need;
    logic [ADDR_W-1:0]         cursor_q;
    logic [SUM_W-1:0]          reach;
    logic                      fits;
    logic [NUM_BUF*ADDR_W-1:0] work_base;
    logic [NUM_BUF*LEN_W-1:0]  work_len;
    logic [NUM_BUF-1:0]        work_ok;
    logic                      work_over;

    ep_alloc_seq #(
        .NUM_BUF (NUM_BUF),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (alloc_req),
        .start    (start),
        .step_en  (step_en),
        .step_idx (step_idx),
        .commit   (commit),
        .busy     (alloc_busy)
    );

    // Hold the configuration for the whole walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            iso_q  <= '0;
            dbl_q  <= '0;
            code_q <= '0;
        end else if (start) begin
            en_q   <= ep_en;
            iso_q  <= ep_iso;
            dbl_q  <= ep_dbl;
            code_q <= ep_code;
        end
    end

    ep_size_decode #(
        .NUM_CFG    (NUM_CFG),
        .IDX_W      (IDX_W),
        .CTRL_BYTES (CTRL_BYTES)
    ) u_dec (
        .idx  (step_idx),
        .en   (en_q),
        .code (code_q),
        .iso  (iso_q),
        .dbl  (dbl_q),
        .want (want),
        .need (need)
    );

    // Capacity test for the buffer under the index.
    always_comb begin
        reach = SUM_W'(cursor_q) + SUM_W'(need);
        fits  = want && (reach <= SUM_W'(BUDGET));
    end

    // Place or reject the indexed buffer and advance the fill cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor_q  <= '0;
            work_base <= '0;
            work_len  <= '0;
            work_ok   <= '0;
            work_over <= 1'b0;
        end else if (start) begin
            cursor_q  <= '0;
            work_over <= 1'b0;
        end else if (step_en) begin
            if (fits) begin
                work_base[step_idx*ADDR_W +: ADDR_W] <= cursor_q;
                work_len[step_idx*LEN_W +: LEN_W]    <= need;
                work_ok[step_idx]                    <= 1'b1;
                cursor_q                             <= reach[ADDR_W-1:0];
            end else begin
                work_base[step_idx*ADDR_W +: ADDR_W] <= '0;
                work_len[step_idx*LEN_W +: LEN_W]    <= '0;
                work_ok[step_idx]                    <= 1'b0;
                if (want) begin
                    work_over <= 1'b1;
                end
            end
        end
    end

    ep_layout_commit #(
        .NUM_BUF    (NUM_BUF),
        .ADDR_W     (ADDR_W),
        .CTRL_BYTES (CTRL_BYTES)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .work_base (work_base),
        .work_len  (work_len),
        .work_ok   (work_ok),
        .work_over (work_over),
        .pub_base  (buf_base),
        .pub_len   (buf_len),
        .pub_ok    (buf_ok),
        .done      (alloc_done),
        .flush     (fifo_flush),
        .err       (over_err)
    );

endmodule

// File: rtl/ep_fifo_alloc_chk.sv
// Property checker for the allocator, bound to every instance of the top.
// Observes only the top's ports.
module ep_fifo_alloc_chk #(
    parameter int NUM_BUF    = 16,
    parameter int ADDR_W     = 12,
    parameter int LEN_W      = 11,
    parameter int CTRL_BYTES = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      alloc_req,
    input logic                      alloc_busy,
    input logic                      alloc_done,
    input logic                      fifo_flush,
    input logic                      over_err,
    input logic [NUM_BUF-1:0]        buf_ok,
    input logic [NUM_BUF*ADDR_W-1:0] buf_base,
    input logic [NUM_BUF*LEN_W-1:0]  buf_len
);

    // R10: done lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |=> !alloc_done);

    // R10: done follows a busy walk and ends it.
    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |-> (!alloc_busy && $past(alloc_busy)));

    // R10: the published layout moves only with done.
    a_r10_layout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_done |-> ($stable(buf_base) && $stable(buf_len) && $stable(buf_ok)));

    // R11: a request during a walk does not end it early.
    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_busy && alloc_req && !alloc_done) |=> (alloc_busy || alloc_done));

    // R12: flush only comes with done.
    a_r12_flush_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> alloc_done);

    // R9: the error flag never clears outside reset.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        over_err |=> over_err);

    // R2: control buffers are always placed first at fixed size.
    a_r2_ctrl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_ok[1:0] == 2'b11) && (buf_len[LEN_W-1:0] == LEN_W'(CTRL_BYTES))
        && (buf_len[2*LEN_W-1:LEN_W] == LEN_W'(CTRL_BYTES))
        && (buf_base[ADDR_W-1:0] == '0)
        && (buf_base[2*ADDR_W-1:ADDR_W] == ADDR_W'(CTRL_BYTES)));

    generate
        for (genvar k = 0; k < NUM_BUF; k++) begin : g_buf
            // R8: an unallocated buffer holds no space and no address.
            a_r8_unalloc_empty: assert property (@(posedge clk) disable iff (!rst_n)
                !buf_ok[k] |-> ((buf_len[k*LEN_W +: LEN_W] == '0)
                               && (buf_base[k*ADDR_W +: ADDR_W] == '0)));
        end
    endgenerate

endmodule

bind ep_fifo_alloc ep_fifo_alloc_chk #(
    .NUM_BUF    (NUM_BUF),
    .ADDR_W     (ADDR_W),
    .LEN_W      (ep_alloc_pkg::LEN_W),
    .CTRL_BYTES (CTRL_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_req),
    .alloc_busy (alloc_busy),
    .alloc_done (alloc_done),
    .fifo_flush (fifo_flush),
    .over_err   (over_err),
    .buf_ok     (buf_ok),
    .buf_base   (buf_base),
    .buf_len    (buf_len)
);

// File: tb/ep_fifo_alloc_bench.sv
// Directed bench for the shared endpoint buffer allocator.
module ep_fifo_alloc_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCFG = 14;
    localparam int NBUF = 16;
    localparam int AW   = 12;
    localparam int LW   = 11;
    localparam int CAP  = 2462;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_req = 1'b0;
    logic [NCFG-1:0]   ep_en = '0, ep_iso = '0, ep_dbl = '0;
    logic [NCFG*4-1:0] ep_code = '0;
    logic              alloc_busy, alloc_done, fifo_flush, over_err;
    logic [NBUF-1:0]   buf_ok;
    logic [NBUF*AW-1:0] buf_base;
    logic [NBUF*LW-1:0] buf_len;

    int total = 0;
    int bad = 0;
    int eb[NBUF];
    int el[NBUF];
    bit eok[NBUF];
    bit eover;
    bit exp_err = 0;
    int pb[NBUF];
    int pl[NBUF];

    ep_fifo_alloc u_ep_fifo_alloc (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
        .ep_en(ep_en), .ep_code(ep_code), .ep_iso(ep_iso), .ep_dbl(ep_dbl),
        .alloc_busy(alloc_busy), .alloc_done(alloc_done), .fifo_flush(fifo_flush),
        .over_err(over_err), .buf_ok(buf_ok), .buf_base(buf_base), .buf_len(buf_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int iso_bytes(input int c);
        int t[16] = '{16, 32, 48, 64, 96, 128, 160, 192,
                      256, 320, 384, 512, 640, 768, 896, 1023};
        return t[c];
    endfunction

    // Reference layout from the requirements (R2..R8).
    task automatic model();
        int cur = 0;
        eover = 0;
        for (int i = 0; i < NBUF; i++) begin
            bit w;
            int n;
            if (i < 2) begin
                w = 1; n = 64;
            end else begin
                int e = i - 2;
                int c = int'(ep_code[e*4 +: 4]);
                w = ep_en[e];
                n = ep_iso[e] ? iso_bytes(c) : ((c >= 3) ? 64 : (8 << c));
                if (ep_dbl[e]) n = n * 2;
            end
            if (w && (cur + n <= CAP)) begin
                eb[i] = cur; el[i] = n; eok[i] = 1; cur += n;
            end else begin
                eb[i] = 0; el[i] = 0; eok[i] = 0;
                if (w) eover = 1;
            end
        end
    endtask

    task automatic set_ep(input int n, input bit e, input int c, input bit i, input bit d);
        ep_en[n-1]  = e;
        ep_iso[n-1] = i;
        ep_dbl[n-1] = d;
        ep_code[(n-1)*4 +: 4] = 4'(c);
    endtask

    task automatic clear_cfg();
        ep_en = '0; ep_iso = '0; ep_dbl = '0; ep_code = '0;
    endtask

    task automatic cmp_layout(input string req);
        for (int i = 0; i < NBUF; i++) begin
            int ab = int'(buf_base[i*AW +: AW]);
            int al = int'(buf_len[i*LW +: LW]);
            if (ab != eb[i] || al != el[i] || buf_ok[i] != eok[i]) begin
                chk(0, req, $sformatf("buf%0d base/len/ok=%0d/%0d/%0d exp base/len/ok", i, ab, al, buf_ok[i]),
                    eb[i] * 10000 + el[i], eb[i] * 10000 + el[i]);
                return;
            end
        end
        chk(1, req, "layout", 0, 0);
    endtask

    // Issue one request, time the walk, check the published result.
    task automatic run_walk(input string req, input bit mid_poke);
        int cyc = 0;
        bit exp_flush = 0;
        model();
        for (int i = 0; i < NBUF; i++)
            if (eb[i] != pb[i] || el[i] != pl[i]) exp_flush = 1;
        @(negedge clk); alloc_req = 1'b1;
        @(negedge clk); alloc_req = 1'b0;
        chk(alloc_busy == 1'b1, "R10", "busy after request", alloc_busy, 1);
        while (!alloc_done && cyc < 60) begin
            cyc++;
            if (mid_poke && cyc == 4) begin
                ep_en = ~ep_en; ep_code = ~ep_code; alloc_req = 1'b1;
            end
            if (mid_poke && cyc == 5) alloc_req = 1'b0;
            if (cyc == 8) begin
                chk(int'(buf_len[2*LW +: LW]) == pl[2], "R10", "layout held mid-walk",
                    int'(buf_len[2*LW +: LW]), pl[2]);
            end
            if (!alloc_done) @(negedge clk);
        end
        chk(cyc == 17, "R10", "edges to done", cyc, 17);
        cmp_layout(req);
        chk(fifo_flush == exp_flush, "R12", "flush with done", fifo_flush, exp_flush);
        exp_err = exp_err | eover;
        chk(over_err == exp_err, "R9", "over_err", over_err, exp_err);
        for (int i = 0; i < NBUF; i++) begin pb[i] = eb[i]; pl[i] = el[i]; end
        @(negedge clk);
        chk(alloc_done == 1'b0 && fifo_flush == 1'b0 && alloc_busy == 1'b0, "R10",
            "strobes drop", alloc_done + fifo_flush + alloc_busy, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NBUF; i++) begin
            eb[i] = (i == 1) ? 64 : 0; el[i] = (i < 2) ? 64 : 0; eok[i] = (i < 2);
            pb[i] = eb[i]; pl[i] = el[i];
        end
        cmp_layout("R1");
        chk(buf_ok == 16'h0003, "R1", "buf_ok", int'(buf_ok), 3);
        chk({over_err, alloc_done, fifo_flush, alloc_busy} == 4'b0, "R1", "flags",
            int'({over_err, alloc_done, fifo_flush, alloc_busy}), 0);
    endtask

    task automatic t_basic();
        clear_cfg();
        set_ep(1, 1, 0, 0, 0);
        set_ep(2, 1, 3, 0, 0);
        set_ep(5, 1, 2, 0, 1);
        run_walk("R2 R4 R6 R7", 0);
        chk(int'(buf_base[6*AW +: AW]) == 200, "R7", "ep5 base", int'(buf_base[6*AW +: AW]), 200);
        chk(int'(buf_len[6*LW +: LW]) == 64, "R6", "ep5 doubled", int'(buf_len[6*LW +: LW]), 64);
    endtask

    task automatic t_repeat();
        run_walk("R12", 0);
    endtask

    task automatic t_iso();
        clear_cfg();
        set_ep(1, 1, 15, 1, 0);
        set_ep(3, 1, 9, 0, 0);
        set_ep(4, 1, 4, 1, 1);
        set_ep(14, 1, 0, 1, 0);
        run_walk("R4 R5 R6", 0);
        chk(int'(buf_len[2*LW +: LW]) == 1023, "R5", "iso code 15", int'(buf_len[2*LW +: LW]), 1023);
        chk(int'(buf_len[4*LW +: LW]) == 64, "R4", "code clamp", int'(buf_len[4*LW +: LW]), 64);
        chk(int'(buf_len[15*LW +: LW]) == 16, "R5", "iso code 0", int'(buf_len[15*LW +: LW]), 16);
    endtask

    task automatic t_disabled();
        clear_cfg();
        set_ep(6, 0, 15, 1, 1);
        set_ep(7, 1, 1, 0, 0);
        run_walk("R3 R7", 0);
        chk(buf_ok[7] == 0 && int'(buf_len[7*LW +: LW]) == 0, "R3", "disabled len",
            int'(buf_len[7*LW +: LW]), 0);
        chk(int'(buf_base[8*AW +: AW]) == 128, "R7", "next packs", int'(buf_base[8*AW +: AW]), 128);
    endtask

    task automatic t_exact();
        clear_cfg();
        set_ep(1, 1, 15, 1, 1);
        set_ep(2, 1, 8, 1, 0);
        set_ep(3, 1, 2, 0, 0);
        run_walk("R8", 0);
        chk(buf_ok[4] == 1 && int'(buf_base[4*AW +: AW]) == 2430, "R8", "exact fit base",
            int'(buf_base[4*AW +: AW]), 2430);
        chk(over_err == 0, "R8", "no error at exact fit", over_err, 0);
    endtask

    task automatic t_busy();
        clear_cfg();
        set_ep(2, 1, 1, 0, 0);
        set_ep(9, 1, 5, 1, 0);
        run_walk("R11", 1);
    endtask

    task automatic t_over();
        clear_cfg();
        set_ep(1, 1, 15, 1, 1);
        set_ep(2, 1, 15, 1, 0);
        set_ep(3, 1, 8, 1, 0);
        set_ep(4, 1, 2, 0, 0);
        set_ep(5, 1, 0, 0, 0);
        run_walk("R8 R9", 0);
        chk(buf_ok[3] == 0 && buf_ok[4] == 1, "R8", "skip then fit", int'(buf_ok[4:3]), 2);
        chk(int'(buf_base[5*AW +: AW]) == 2430, "R8", "later base", int'(buf_base[5*AW +: AW]), 2430);
        chk(over_err == 1, "R9", "error raised", over_err, 1);
    endtask

    task automatic t_sticky();
        clear_cfg();
        set_ep(1, 1, 0, 0, 0);
        run_walk("R9", 0);
        chk(over_err == 1, "R9", "error stays", over_err, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_repeat();
        t_iso();
        t_disabled();
        t_exact();
        t_busy();
        t_over();
        t_sticky();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule